// File: doc/BRIEF.md
# Seed-Neighbour Hit Cluster Finder

The block receives pedestal-corrected pixel amplitudes in raster order, one row after another. Each amplitude comes with the noise figure (pedestal spread) of its pixel. The block finds particle hits as they stream past. A pixel starts a hit when its amplitude clearly rises above its own noise. Adjacent pixels in the 3x3 box around it are added when they pass a looser cut. For every hit the block emits one compact record: seed row, seed column, member count and summed charge. Pixels that belong to no hit never reach the output.

Three row buffers hold the row above, the row being judged and the row below. After a complete row arrives, the middle row is scanned one column per cycle. Input is held off (`in_ready` low) during the scan. Records enter a small output FIFO. When that FIFO is full the scan pauses, and the input stays blocked until the scan has finished.

Back-pressure rules:
- An input pixel is taken on a cycle where `in_valid` and `in_ready` are both high.
- An output record is taken on a cycle where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the record on the output holds still.

Threshold multipliers are unsigned fixed point with `K_FRAC` fractional bits. They must not change during a frame. Every row is exactly `COLS` pixels wide, and `in_eof` marks the last pixel of a frame.

Top module: `hit_cluster_finder`

## Requirements
- R1: A pixel is a seed only when amp*2^K_FRAC > cfg_seed_k*noise (strictly greater; with K_FRAC=4, a multiplier of 80 means 5.0). An amplitude of exactly 5.0 noise produces no record.
- R2: A non-seed pixel in the window joins a cluster when amp*2^K_FRAC >= cfg_nbr_k*noise (equality joins; 32 means 2.0).
- R3: Only the eight pixels adjacent to the seed (3x3 box) can be members. A qualifying pixel two columns away is not counted.
- R4: A seed forms a cluster only if no other seed in its 3x3 box has a larger amplitude. When amplitudes are equal, the seed earlier in raster order (lower row, then lower column) wins.
- R5: Each pixel belongs to at most one cluster. A pixel adjacent to two winning seeds goes to the seed that comes first in raster order.
- R6: Positions outside the matrix (first/last row, first/last column) are never counted as members.
- R7: A record carries the seed row, the seed column, a count from 1 to 9 (seed plus members) and the signed sum of the member amplitudes including the seed.
- R8: A frame with no seed produces no record.
- R9: A record holds stable while `out_ready` is low. A full FIFO pauses the scan, which keeps `in_ready` low; no record is lost.
- R10: The clusters of a row are emitted only after the following row has fully arrived. The `in_eof` pixel causes the last row to be scanned without a row below.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_seed_k | input | K_W | Seed multiplier, fixed point |
| cfg_nbr_k | input | K_W | Neighbour multiplier, fixed point |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel |
| in_amp | input | AMP_W | Signed pedestal-corrected amplitude |
| in_noise | input | NOISE_W | Pixel noise value |
| in_eof | input | 1 | Last pixel of the frame |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_row | output | ROW_W | Seed row |
| out_col | output | $clog2(COLS) | Seed column |
| out_count | output | 4 | Member count, 1 to 9 |
| out_charge | output | AMP_W+4 | Summed charge |

## Verification
On every cycle, assertions check four things:
- the output FIFO is never pushed while full;
- a stalled record stays unchanged;
- every emitted record has a count between 1 and 9 and a positive charge;
- a winning seed has never already been taken by an earlier cluster.

Only the bench scenarios can show the rest: the exact threshold boundaries, the local-maximum and tie decisions, the raster-order handover of shared pixels, edge trimming, the one-row delay before emission, and the end-of-frame flush.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int CNT_W = 4;
  typedef enum logic [1:0] {ST_FILL, ST_ROWEND, ST_SCAN} hc_state_t;
endpackage

// File: rtl/hc_thresh.sv
module hc_thresh #(
  parameter int AMP_W   = 12,
  parameter int NOISE_W = 10,
  parameter int K_W     = 8,
  parameter int K_FRAC  = 4
) (
  input  logic signed [AMP_W-1:0] amp,
  input  logic [NOISE_W-1:0]      noise,
  input  logic [K_W-1:0]          k_seed,
  input  logic [K_W-1:0]          k_nbr,
  output logic                    is_seed,
  output logic                    is_nbr
);
  localparam int LW = AMP_W + K_FRAC;
  localparam int RW = NOISE_W + K_W;
  localparam int PW = ((LW > RW) ? LW : RW) + 2;

  logic signed [PW-1:0] lhs, rhs_s, rhs_n;
  logic [PW-1:0] prod_s, prod_n;

  always_comb begin
    lhs    = PW'(amp) <<< K_FRAC;
    prod_s = PW'(k_seed) * PW'(noise);
    prod_n = PW'(k_nbr) * PW'(noise);
    rhs_s  = signed'(prod_s);
    rhs_n  = signed'(prod_n);
    is_seed = lhs > rhs_s;
    is_nbr  = lhs >= rhs_n;
  end
endmodule

// File: rtl/hc_window_eval.sv
module hc_window_eval #(
  parameter int AMP_W = 12,
  parameter int CH_W  = 16
) (
  input  logic signed [AMP_W-1:0] amp [9],
  input  logic [8:0]              present,
  input  logic [8:0]              seed,
  input  logic [8:0]              nbr,
  input  logic [8:0]              claimed,
  output logic                    win,
  output logic [3:0]              count,
  output logic signed [CH_W-1:0]  charge,
  output logic [8:0]              take
);
  always_comb begin
    win = present[4] & seed[4];
    for (int k = 0; k < 9; k++) begin
      if (k != 4 && present[k] && seed[k]) begin
        if (k < 4) begin
          if (amp[4] <= amp[k]) win = 1'b0;
        end else begin
          if (amp[4] < amp[k]) win = 1'b0;
        end
      end
    end
    take   = '0;
    count  = '0;
    charge = '0;
    if (win) begin
      take[4] = 1'b1;
      count   = 4'd1;
      charge  = CH_W'(amp[4]);
      for (int k = 0; k < 9; k++) begin
        if (k != 4 && present[k] && nbr[k] && !claimed[k]) begin
          take[k] = 1'b1;
          count   = count + 4'd1;
          charge  = charge + CH_W'(amp[k]);
        end
      end
    end
  end
endmodule

// File: rtl/hc_fifo.sv
module hc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] used;
  logic             pop;

  assign full      = (used == CNT_W'(DEPTH));
  assign out_valid = (used != '0);
  assign out_data  = mem[rptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      used <= '0;
    end else begin
      if (push && !full) begin
        mem[wptr] <= push_data;
        wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (pop) rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
      used <= used + CNT_W'(push && !full) - CNT_W'(pop);
    end
  end

  assert_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/hit_cluster_finder.sv
module hit_cluster_finder #(
  parameter int COLS       = 16,
  parameter int ROW_W      = 8,
  parameter int AMP_W      = 12,
  parameter int NOISE_W    = 10,
  parameter int K_W        = 8,
  parameter int K_FRAC     = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [K_W-1:0]                cfg_seed_k,
  input  logic [K_W-1:0]                cfg_nbr_k,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic signed [AMP_W-1:0]       in_amp,
  input  logic [NOISE_W-1:0]            in_noise,
  input  logic                          in_eof,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [ROW_W-1:0]              out_row,
  output logic [$clog2(COLS)-1:0]       out_col,
  output logic [3:0]                    out_count,
  output logic signed [AMP_W+3:0]       out_charge
);
  import hc_pkg::*;

  localparam int COL_W = $clog2(COLS);
  localparam int CH_W  = AMP_W + 4;
  localparam int REC_W = ROW_W + COL_W + CNT_W + CH_W;

  hc_state_t state;
  logic [COL_W-1:0] wcol, sc;
  logic [ROW_W-1:0] in_row, low_row, mid_row;
  logic mid_ok, up_ok, below_ok, eof_pend;

  logic signed [AMP_W-1:0] up_amp [COLS];
  logic signed [AMP_W-1:0] mid_amp [COLS];
  logic signed [AMP_W-1:0] low_amp [COLS];
  logic [COLS-1:0] up_sd, mid_sd, low_sd, up_nb, mid_nb, low_nb;
  logic [COLS-1:0] up_cl, mid_cl, low_cl, up_cl_n, mid_cl_n, low_cl_n;

  logic px_seed, px_nbr;
  logic signed [AMP_W-1:0] w_amp [9];
  logic [8:0] w_pr, w_sd, w_nb, w_cl, take;
  logic [COL_W-1:0] wci [3];
  logic win, adv, push, fifo_full;
  logic [3:0] w_count;
  logic signed [CH_W-1:0] w_charge;
  logic [REC_W-1:0] rec_in, rec_out;

  assign in_ready = (state == ST_FILL);
  assign adv      = (state == ST_SCAN) && !fifo_full;
  assign push     = adv && win;

  hc_thresh #(.AMP_W(AMP_W), .NOISE_W(NOISE_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_thresh (
    .amp(in_amp), .noise(in_noise), .k_seed(cfg_seed_k), .k_nbr(cfg_nbr_k),
    .is_seed(px_seed), .is_nbr(px_nbr));

  // gather the 3x3 window around the scan column
  always_comb begin
    int cc;
    logic inr;
    for (int dc = 0; dc < 3; dc++) begin
      cc  = int'(sc) + dc - 1;
      inr = (cc >= 0) && (cc < COLS);
      wci[dc] = inr ? COL_W'(cc) : '0;
      w_amp[dc]   = up_amp[wci[dc]];
      w_amp[3+dc] = mid_amp[wci[dc]];
      w_amp[6+dc] = low_amp[wci[dc]];
      w_pr[dc]    = inr && up_ok;
      w_pr[3+dc]  = inr && mid_ok;
      w_pr[6+dc]  = inr && below_ok;
      w_sd[dc]    = up_sd[wci[dc]];
      w_sd[3+dc]  = mid_sd[wci[dc]];
      w_sd[6+dc]  = low_sd[wci[dc]];
      w_nb[dc]    = up_nb[wci[dc]];
      w_nb[3+dc]  = mid_nb[wci[dc]];
      w_nb[6+dc]  = low_nb[wci[dc]];
      w_cl[dc]    = up_cl[wci[dc]];
      w_cl[3+dc]  = mid_cl[wci[dc]];
      w_cl[6+dc]  = low_cl[wci[dc]];
    end
  end

  hc_window_eval #(.AMP_W(AMP_W), .CH_W(CH_W)) u_eval (
    .amp(w_amp), .present(w_pr), .seed(w_sd), .nbr(w_nb), .claimed(w_cl),
    .win(win), .count(w_count), .charge(w_charge), .take(take));

  // claim bits after this cycle's cluster
  always_comb begin
    up_cl_n  = up_cl;
    mid_cl_n = mid_cl;
    low_cl_n = low_cl;
    if (push) begin
      for (int dc = 0; dc < 3; dc++) begin
        if (take[dc])   up_cl_n[wci[dc]]  = 1'b1;
        if (take[3+dc]) mid_cl_n[wci[dc]] = 1'b1;
        if (take[6+dc]) low_cl_n[wci[dc]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      wcol     <= '0;
      sc       <= '0;
      in_row   <= '0;
      low_row  <= '0;
      mid_row  <= '0;
      mid_ok   <= 1'b0;
      up_ok    <= 1'b0;
      below_ok <= 1'b0;
      eof_pend <= 1'b0;
      up_sd <= '0; mid_sd <= '0; low_sd <= '0;
      up_nb <= '0; mid_nb <= '0; low_nb <= '0;
      up_cl <= '0; mid_cl <= '0; low_cl <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (in_valid) begin
            low_amp[wcol] <= in_amp;
            low_sd[wcol]  <= px_seed;
            low_nb[wcol]  <= px_nbr;
            low_cl[wcol]  <= 1'b0;
            if (wcol == COL_W'(COLS-1) || in_eof) begin
              wcol     <= '0;
              low_row  <= in_row;
              in_row   <= in_eof ? '0 : in_row + 1'b1;
              eof_pend <= in_eof;
              state    <= ST_ROWEND;
            end else begin
              wcol <= wcol + 1'b1;
            end
          end
        end
        ST_ROWEND: begin
          sc <= '0;
          if (mid_ok) begin
            below_ok <= 1'b1;
            state    <= ST_SCAN;
          end else begin
            up_amp <= mid_amp; up_sd <= mid_sd; up_nb <= mid_nb; up_cl <= mid_cl;
            mid_amp <= low_amp; mid_sd <= low_sd; mid_nb <= low_nb; mid_cl <= low_cl;
            up_ok   <= 1'b0;
            mid_ok  <= 1'b1;
            mid_row <= low_row;
            if (eof_pend) begin
              eof_pend <= 1'b0;
              below_ok <= 1'b0;
              state    <= ST_SCAN;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_SCAN: begin
          if (adv) begin
            up_cl  <= up_cl_n;
            mid_cl <= mid_cl_n;
            low_cl <= low_cl_n;
            if (sc == COL_W'(COLS-1)) begin
              sc <= '0;
              if (below_ok) begin
                up_amp <= mid_amp; up_sd <= mid_sd; up_nb <= mid_nb; up_cl <= mid_cl_n;
                mid_amp <= low_amp; mid_sd <= low_sd; mid_nb <= low_nb; mid_cl <= low_cl_n;
                up_ok   <= 1'b1;
                mid_row <= low_row;
                if (eof_pend) begin
                  eof_pend <= 1'b0;
                  below_ok <= 1'b0;
                end else begin
                  state <= ST_FILL;
                end
              end else begin
                mid_ok <= 1'b0;
                up_ok  <= 1'b0;
                state  <= ST_FILL;
              end
            end else begin
              sc <= sc + 1'b1;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  assign rec_in = {mid_row, sc, w_count, w_charge};

  hc_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rec_in), .full(fifo_full),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(rec_out));

  assign {out_row, out_col, out_count, out_charge} = rec_out;

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= 4'd1 && out_count <= 4'd9));
  assert_charge_positive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_charge > 0));
  assert_seed_unclaimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !w_cl[4]);
endmodule

// File: tb/hit_cluster_finder_bench.sv
module hit_cluster_finder_bench;
  localparam int NC = 6;
  localparam int NR = 4;
  localparam int NOISE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_seed_k = 8'd80;
  logic [7:0] cfg_nbr_k  = 8'd32;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [11:0] in_amp = '0;
  logic [9:0] in_noise = '0;
  logic in_eof = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_row;
  logic [2:0] out_col;
  logic [3:0] out_count;
  logic signed [15:0] out_charge;

  always #2 clk = ~clk;

  hit_cluster_finder #(.COLS(NC)) u_hit_cluster_finder (
    .clk(clk), .rst_n(rst_n), .cfg_seed_k(cfg_seed_k), .cfg_nbr_k(cfg_nbr_k),
    .in_valid(in_valid), .in_ready(in_ready), .in_amp(in_amp), .in_noise(in_noise),
    .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_col(out_col), .out_count(out_count), .out_charge(out_charge));

  int n_chk = 0;
  int n_fail = 0;
  int fa [NR][NC];
  int rrow [64], rcol [64], rcnt [64], rchg [64];
  int rec_n = 0;
  int cyc = 0;

  // seed row, seed col, seed amp, neighbour amp, record expected
  localparam int VEC [6][5] = '{
    '{1, 2, 51, 20, 1},
    '{1, 2, 50, 20, 0},
    '{1, 2, 60, 19, 1},
    '{0, 0, 80, 25, 1},
    '{3, 5, 70, 30, 1},
    '{2, 0, 55, 20, 1}
  };

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rec_n < 64) begin
      rrow[rec_n] = int'(out_row);
      rcol[rec_n] = int'(out_col);
      rcnt[rec_n] = int'(out_count);
      rchg[rec_n] = int'(out_charge);
      rec_n = rec_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic clear_frame();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) fa[r][c] = 0;
  endtask

  task automatic send_row(input int r);
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_amp   = 12'(fa[r][c]);
      in_noise = 10'(NOISE);
      in_eof   = (r == NR-1) && (c == NC-1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic send_frame();
    for (int r = 0; r < NR; r++) send_row(r);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rec(input string tag, input int idx, input int r, input int c,
                         input int cnt, input int chg);
    chk_eq({tag, " row"}, rrow[idx], r);
    chk_eq({tag, " col"}, rcol[idx], c);
    chk_eq({tag, " count"}, rcnt[idx], cnt);
    chk_eq({tag, " charge"}, rchg[idx], chg);
  endtask

  initial begin
    int base;
    int first_row, first_col, first_chg;
    bit moved;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_eq("R11 in_ready after reset", int'(in_ready), 1);
    chk_eq("R11 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    idle(2);

    // table walk: R1 R2 R3 R6 R7 R10
    for (int v = 0; v < 6; v++) begin
      int sr, scol, sa, na, ecnt, echg, far_c;
      sr = VEC[v][0]; scol = VEC[v][1]; sa = VEC[v][2]; na = VEC[v][3];
      clear_frame();
      fa[sr][scol] = sa;
      ecnt = 1; echg = sa;
      for (int dr = -1; dr <= 1; dr++)
        for (int dc = -1; dc <= 1; dc++)
          if (!(dr == 0 && dc == 0) && sr+dr >= 0 && sr+dr < NR && scol+dc >= 0 && scol+dc < NC) begin
            fa[sr+dr][scol+dc] = na;
            if (na >= 2*NOISE) begin ecnt++; echg += na; end
          end
      far_c = (scol + 2 < NC) ? scol + 2 : scol - 2;
      fa[sr][far_c] = 45;   // R3: qualifies but lies outside the box
      base = rec_n;
      send_frame();
      idle(40);
      chk_eq($sformatf("R1 R2 vec%0d record count", v), rec_n - base, VEC[v][4]);
      if (VEC[v][4] == 1 && rec_n > base)
        chk_rec($sformatf("R3 R6 R7 vec%0d", v), base, sr, scol, ecnt, echg);
    end

    // R8 empty frame
    clear_frame();
    base = rec_n;
    send_frame();
    idle(40);
    chk_eq("R8 empty frame records", rec_n - base, 0);

    // R4 larger neighbour seed wins
    clear_frame();
    fa[1][1] = 70; fa[1][2] = 90;
    base = rec_n;
    send_frame(); idle(40);
    chk_eq("R4 adjacent seeds records", rec_n - base, 1);
    chk_rec("R4 adjacent", base, 1, 2, 2, 160);

    // R4 tie goes to lower row
    clear_frame();
    fa[1][1] = 70; fa[2][2] = 70;
    base = rec_n;
    send_frame(); idle(40);
    chk_eq("R4 tie records", rec_n - base, 1);
    chk_rec("R4 tie", base, 1, 1, 2, 140);

    // R5 shared neighbour goes to earlier seed
    clear_frame();
    fa[1][1] = 80; fa[1][2] = 30; fa[1][3] = 90;
    base = rec_n;
    send_frame(); idle(40);
    chk_eq("R5 shared records", rec_n - base, 2);
    chk_rec("R5 first", base, 1, 1, 2, 110);
    chk_rec("R5 second", base + 1, 1, 3, 1, 90);

    // R10 row held until the next row arrives
    clear_frame();
    fa[0][1] = 90;
    base = rec_n;
    send_row(0);
    idle(30);
    chk_eq("R10 no record before next row", rec_n - base, 0);
    for (int r = 1; r < NR; r++) send_row(r);
    idle(40);
    chk_eq("R10 record after next row", rec_n - base, 1);
    chk_rec("R10", base, 0, 1, 1, 90);

    // R9 back-pressure with six separated seeds
    clear_frame();
    fa[0][0] = 60; fa[0][2] = 60; fa[0][4] = 60;
    fa[2][0] = 60; fa[2][2] = 60; fa[2][4] = 60;
    @(negedge clk);
    out_ready = 1'b0;
    base = rec_n;
    send_frame();
    idle(50);
    chk_eq("R9 out_valid while stalled", int'(out_valid), 1);
    chk_eq("R9 in_ready low while FIFO full", int'(in_ready), 0);
    first_row = int'(out_row); first_col = int'(out_col); first_chg = int'(out_charge);
    moved = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (int'(out_row) != first_row || int'(out_col) != first_col || int'(out_charge) != first_chg)
        moved = 1'b1;
    end
    chk_eq("R9 record stable while stalled", int'(moved), 0);
    out_ready = 1'b1;
    idle(60);
    chk_eq("R9 all records delivered", rec_n - base, 6);
    for (int i = 0; i < 6; i++)
      chk_rec($sformatf("R9 rec%0d", i), base + i, (i < 3) ? 0 : 2, 2 * (i % 3), 1, 60);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule